// File: doc/BRIEF.md
# Idle and Ordered-Set Word Deleter

This block is a receive-side rate-matching stage for a 10GBASE-R style datapath. It sits in front of a clock-compensation FIFO. Each beat carries two 32-bit words, a lower word and an upper word, and each word has four control bits. While the FIFO reports that it is nearly full, the block removes Idle and ordered-set words that can be dropped safely. Whether a word can be dropped depends on the word beside it or the word just before it. The block never removes a Start, a Terminate or a data word.

The surviving words are packed back into full two-word beats. A one-word carry register holds the odd word when a single word was removed. When fewer than two words are ready, no beat is written, and the next beat that is written carries a deletion marker in bit 8 of its control field. A separate one-cycle status pulse reports that a deletion happened. This pulse does not travel with the data.

The input and output follow valid/ready rules. An input beat is taken on a clock edge where `i_valid` and `i_ready` are both high. `i_ready` is high whenever the output register is empty or is being drained (`o_ready` high). While `o_valid` is high and `o_ready` is low, the output beat stays frozen and no input is taken. `i_pfull` is plain status, sampled together with each accepted beat.

Top module: `rx_idle_deleter`

## Requirements
- R1: A word's type comes from control bit 0 and byte 0 of that word. With control bit 0 set, the byte values are: 0x07 Idle, 0x9C ordered set, 0xFD Terminate, 0xFB Start. With control bit 0 clear, the word is data, whatever its byte 0 holds.
- R2: The lower word of an accepted beat is deleted when `i_pfull` is high and either of these holds: the word is Idle and the upper word of the previously accepted beat is not a Terminate; or the word is an ordered set and that previous upper word is also an ordered set.
- R3: The upper word of an accepted beat is deleted when `i_pfull` is high and either of these holds: the word is Idle and the lower word of the same beat is not a Terminate; or both words of the beat are ordered sets.
- R4: No word is deleted while `i_pfull` is low. Start, Terminate and data words are never deleted.
- R5: The surviving words leave in their arrival order, two per output beat. Any word held in the carry register leaves ahead of the words of the next accepted beat.
- R6: An accepted beat that leaves fewer than two words ready (carry plus survivors) produces no output beat, and `o_valid` is low in the following cycle.
- R7: `o_ctl[3:0]` holds the control bits of the output lower word and `o_ctl[7:4]` those of the output upper word. `o_ctl[8]` is set on the first output beat written after a withheld beat, and on no other beat.
- R8: `o_del` is high for exactly one cycle, the cycle after an accepted beat in which at least one word was deleted.
- R9: `i_ready` is low only while `o_valid` is high and `o_ready` is low. During such a stall, `o_valid` and all output fields stay stable.
- R10: Reset empties the output register and the carry register, clears the pending marker and `o_del`, and makes the previous upper word count as data.
- R11: The result of an accepted beat appears on the outputs in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Input beat present |
| i_ready | output | 1 | Input beat can be taken |
| i_lo_data | input | 32 | Lower word data |
| i_lo_ctl | input | 4 | Lower word control bits |
| i_hi_data | input | 32 | Upper word data |
| i_hi_ctl | input | 4 | Upper word control bits |
| i_pfull | input | 1 | FIFO nearly full; enables deletion |
| o_valid | output | 1 | Output beat present |
| o_ready | input | 1 | Downstream accepts output beat |
| o_lo_data | output | 32 | Output lower word data |
| o_hi_data | output | 32 | Output upper word data |
| o_ctl | output | 9 | Control bits of both words plus deletion marker in bit 8 |
| o_del | output | 1 | One-cycle deletion status pulse |

## Verification
The result of each accepted beat (the output words, `o_valid`, the marker bit and the `o_del` pulse) is due exactly one clock after the accepting edge. `i_ready` follows the output state and `o_ready` in the same cycle. The bench drives each beat at a falling edge and compares every output at the next falling edge, so each comparison sees the effect of exactly one accepting edge. The stall test checks `i_ready` just after driving and confirms at the next falling edge that the held beat did not change.

// File: rtl/rmx_pkg.sv
`timescale 1ns/1ps
package rmx_pkg;

  typedef enum logic [2:0] {
    WK_DATA  = 3'd0,
    WK_IDLE  = 3'd1,
    WK_OS    = 3'd2,
    WK_TERM  = 3'd3,
    WK_START = 3'd4
  } wkind_t;

  localparam logic [7:0] CODE_IDLE  = 8'h07;
  localparam logic [7:0] CODE_OS    = 8'h9C;
  localparam logic [7:0] CODE_TERM  = 8'hFD;
  localparam logic [7:0] CODE_START = 8'hFB;

endpackage

// File: rtl/rmx_word_class.sv
`timescale 1ns/1ps
module rmx_word_class #(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0] lead_byte,
  input  logic [LANES-1:0]   lead_ctl,
  output rmx_pkg::wkind_t    kind [LANES]
);
  import rmx_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b;
    assign b = lead_byte[g*8 +: 8];
    always_comb begin
      kind[g] = WK_DATA;
      if (lead_ctl[g]) begin
        unique case (b)
          CODE_IDLE:  kind[g] = WK_IDLE;
          CODE_OS:    kind[g] = WK_OS;
          CODE_TERM:  kind[g] = WK_TERM;
          CODE_START: kind[g] = WK_START;
          default:    kind[g] = WK_DATA;
        endcase
      end
    end
  end

endmodule

// File: rtl/rmx_del_decide.sv
`timescale 1ns/1ps
module rmx_del_decide (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            pfull,
  input  rmx_pkg::wkind_t kind_lo,
  input  rmx_pkg::wkind_t kind_hi,
  output logic            del_lo,
  output logic            del_hi
);
  import rmx_pkg::*;

  wkind_t prev_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_hi <= WK_DATA;
    else if (adv) prev_hi <= kind_hi;
  end

  always_comb begin
    del_lo = pfull &&
             ((kind_lo == WK_IDLE && prev_hi != WK_TERM) ||
              (kind_lo == WK_OS   && prev_hi == WK_OS));
    del_hi = pfull &&
             ((kind_hi == WK_IDLE && kind_lo != WK_TERM) ||
              (kind_hi == WK_OS   && kind_lo == WK_OS));
  end

endmodule

// File: rtl/rmx_compact.sv
`timescale 1ns/1ps
module rmx_compact #(
  parameter int WW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          keep_lo,
  input  logic          keep_hi,
  input  logic [WW-1:0] w_lo,
  input  logic [WW-1:0] w_hi,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [WW-1:0] out_lo,
  output logic [WW-1:0] out_hi,
  output logic          out_mark
);

  logic          carry_v;
  logic [WW-1:0] carry_w;
  logic          pend;

  logic [1:0]    n_keep;
  logic [1:0]    total;
  logic [WW-1:0] s0, c0, c1;

  always_comb begin
    n_keep = {1'b0, keep_lo} + {1'b0, keep_hi};
    total  = n_keep + {1'b0, carry_v};
    s0     = keep_lo ? w_lo : w_hi;
    c0     = carry_v ? carry_w : s0;
    c1     = carry_v ? s0 : w_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_v   <= 1'b0;
      carry_w   <= '0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_mark  <= 1'b0;
    end else if (adv) begin
      if (total >= 2'd2) begin
        out_valid <= 1'b1;
        out_lo    <= c0;
        out_hi    <= c1;
        out_mark  <= pend;
        pend      <= 1'b0;
        carry_v   <= (total == 2'd3);
        carry_w   <= w_hi;
      end else begin
        out_valid <= 1'b0;
        pend      <= 1'b1;
        carry_v   <= (total == 2'd1);
        carry_w   <= c0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_idle_deleter.sv
`timescale 1ns/1ps
module rx_idle_deleter #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  output logic            i_ready,
  input  logic [DW-1:0]   i_lo_data,
  input  logic [DW/8-1:0] i_lo_ctl,
  input  logic [DW-1:0]   i_hi_data,
  input  logic [DW/8-1:0] i_hi_ctl,
  input  logic            i_pfull,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [DW-1:0]   o_lo_data,
  output logic [DW-1:0]   o_hi_data,
  output logic [2*(DW/8):0] o_ctl,
  output logic            o_del
);
  import rmx_pkg::*;

  localparam int CW = DW / 8;
  localparam int WW = DW + CW;

  logic          adv;
  logic          del_lo, del_hi;
  wkind_t        kinds [2];
  wkind_t        kind_lo, kind_hi;
  logic [WW-1:0] out_lo, out_hi;
  logic          mark;

  assign i_ready = !o_valid || o_ready;
  assign adv     = i_valid && i_ready;

  rmx_word_class #(.LANES(2)) u_class (
    .lead_byte ({i_hi_data[7:0], i_lo_data[7:0]}),
    .lead_ctl  ({i_hi_ctl[0], i_lo_ctl[0]}),
    .kind      (kinds)
  );

  assign kind_lo = kinds[0];
  assign kind_hi = kinds[1];

  rmx_del_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .pfull   (i_pfull),
    .kind_lo (kind_lo),
    .kind_hi (kind_hi),
    .del_lo  (del_lo),
    .del_hi  (del_hi)
  );

  rmx_compact #(.WW(WW)) u_compact (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .keep_lo   (!del_lo),
    .keep_hi   (!del_hi),
    .w_lo      ({i_lo_ctl, i_lo_data}),
    .w_hi      ({i_hi_ctl, i_hi_data}),
    .out_ready (o_ready),
    .out_valid (o_valid),
    .out_lo    (out_lo),
    .out_hi    (out_hi),
    .out_mark  (mark)
  );

  assign o_lo_data = out_lo[DW-1:0];
  assign o_hi_data = out_hi[DW-1:0];
  assign o_ctl     = {mark, out_hi[WW-1:DW], out_lo[WW-1:DW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_del <= 1'b0;
    else        o_del <= adv && (del_lo || del_hi);
  end

endmodule

// File: rtl/rx_idle_deleter_chk.sv
`timescale 1ns/1ps
module rx_idle_deleter_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            i_valid,
  input logic            i_ready,
  input logic            i_pfull,
  input logic            o_valid,
  input logic            o_ready,
  input logic [31:0]     o_lo_data,
  input logic [31:0]     o_hi_data,
  input logic [8:0]      o_ctl,
  input logic            o_del,
  input logic            del_lo,
  input logic            del_hi,
  input rmx_pkg::wkind_t kind_lo,
  input rmx_pkg::wkind_t kind_hi
);
  import rmx_pkg::*;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_lo_data) &&
                               $stable(o_hi_data) && $stable(o_ctl)));

  // R4
  no_del_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready && !i_pfull) |=> !o_del);

  // R4
  lo_frame_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    del_lo |-> (kind_lo == WK_IDLE || kind_lo == WK_OS));

  // R3
  hi_frame_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    del_hi |-> (kind_hi == WK_IDLE || kind_hi == WK_OS));

  // R8
  del_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_del |-> $past(i_valid && i_ready && i_pfull));

endmodule

bind rx_idle_deleter rx_idle_deleter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .i_valid   (i_valid),
  .i_ready   (i_ready),
  .i_pfull   (i_pfull),
  .o_valid   (o_valid),
  .o_ready   (o_ready),
  .o_lo_data (o_lo_data),
  .o_hi_data (o_hi_data),
  .o_ctl     (o_ctl),
  .o_del     (o_del),
  .del_lo    (del_lo),
  .del_hi    (del_hi),
  .kind_lo   (kind_lo),
  .kind_hi   (kind_hi)
);

// File: tb/sim_rx_idle_deleter.sv
`timescale 1ns/1ps
module sim_rx_idle_deleter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_valid = 1'b0;
  logic        i_ready;
  logic [31:0] i_lo_data = '0, i_hi_data = '0;
  logic [3:0]  i_lo_ctl = '0, i_hi_ctl = '0;
  logic        i_pfull = 1'b0;
  logic        o_valid;
  logic        o_ready = 1'b1;
  logic [31:0] o_lo_data, o_hi_data;
  logic [8:0]  o_ctl;
  logic        o_del;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_idle_deleter u0 (.*);

  localparam logic [2:0] KD = 3'd0, KI = 3'd1, KO = 3'd2, KT = 3'd3, KS = 3'd4;

  // R1 encodings: ctl bit0 + byte0 (07 Idle, 9C OS, FD Term, FB Start); ctl bit0 clear = data
  function automatic logic [35:0] mk(input logic [2:0] k, input logic [7:0] tag);
    case (k)
      KI:      mk = {4'hF, tag, 16'h0707, 8'h07};
      KO:      mk = {4'h1, tag, 16'h0000, 8'h9C};
      KT:      mk = {4'hF, tag, 16'h0707, 8'hFD};
      KS:      mk = {4'h1, tag, 16'h5555, 8'hFB};
      default: mk = {4'h0, tag, 16'h5A5A, 8'h07};
    endcase
  endfunction

  // {lo kind,tag, hi kind,tag, pfull | exp valid, exp lo kind,tag, exp hi kind,tag, exp mark, exp del}
  localparam int NV = 15;
  localparam logic [47:0] VEC [NV] = '{
    {KD,8'd1,  KD,8'd2,  1'b0, 1'b1, KD,8'd1,  KD,8'd2,  1'b0, 1'b0}, // R1 data with byte 07
    {KI,8'd3,  KI,8'd4,  1'b1, 1'b0, KD,8'd0,  KD,8'd0,  1'b0, 1'b1}, // R2 R3 both idles go
    {KD,8'd5,  KT,8'd6,  1'b1, 1'b1, KD,8'd5,  KT,8'd6,  1'b1, 1'b0}, // R4 data/term kept
    {KI,8'd7,  KI,8'd8,  1'b1, 1'b0, KD,8'd0,  KD,8'd0,  1'b0, 1'b1}, // R2 idle after term kept
    {KS,8'd9,  KD,8'd10, 1'b1, 1'b1, KI,8'd7,  KS,8'd9,  1'b1, 1'b0}, // R5 carry first
    {KD,8'd11, KD,8'd12, 1'b0, 1'b1, KD,8'd10, KD,8'd11, 1'b0, 1'b0},
    {KO,8'd13, KO,8'd14, 1'b1, 1'b1, KD,8'd12, KO,8'd13, 1'b0, 1'b1}, // R3 OS pair upper goes
    {KO,8'd15, KO,8'd16, 1'b1, 1'b0, KD,8'd0,  KD,8'd0,  1'b0, 1'b1}, // R2 OS after OS
    {KI,8'd17, KD,8'd18, 1'b0, 1'b1, KI,8'd17, KD,8'd18, 1'b1, 1'b0}, // R4 pfull low
    {KI,8'd19, KI,8'd20, 1'b0, 1'b1, KI,8'd19, KI,8'd20, 1'b0, 1'b0}, // R4 pfull low
    {KT,8'd21, KI,8'd22, 1'b1, 1'b1, KT,8'd21, KI,8'd22, 1'b0, 1'b0}, // R3 idle after term kept
    {KI,8'd23, KO,8'd24, 1'b1, 1'b0, KD,8'd0,  KD,8'd0,  1'b0, 1'b1}, // R3 lone OS kept
    {KD,8'd25, KD,8'd26, 1'b0, 1'b1, KO,8'd24, KD,8'd25, 1'b1, 1'b0},
    {KD,8'd27, KD,8'd28, 1'b0, 1'b1, KD,8'd26, KD,8'd27, 1'b0, 1'b0},
    {KD,8'd29, KD,8'd30, 1'b0, 1'b1, KD,8'd28, KD,8'd29, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] lk, input logic [7:0] lt,
                       input logic [2:0] hk, input logic [7:0] ht, input logic pf);
    logic [35:0] a, b;
    a = mk(lk, lt);
    b = mk(hk, ht);
    i_valid   = 1'b1;
    i_lo_ctl  = a[35:32]; i_lo_data = a[31:0];
    i_hi_ctl  = b[35:32]; i_hi_data = b[31:0];
    i_pfull   = pf;
  endtask

  task automatic chk_beat(input string tag, input logic [2:0] k0, input logic [7:0] t0,
                          input logic [2:0] k1, input logic [7:0] t1, input logic m);
    chk("R11", {tag, " valid"}, 64'(o_valid), 64'(1'b1));
    chk("R5",  {tag, " lo word"}, 64'({o_ctl[3:0], o_lo_data}), 64'(mk(k0, t0)));
    chk("R5",  {tag, " hi word"}, 64'({o_ctl[7:4], o_hi_data}), 64'(mk(k1, t1)));
    chk("R7",  {tag, " mark"}, 64'(o_ctl[8]), 64'(m));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset o_valid", 64'(o_valid), 64'(1'b0));
    chk("R10", "reset o_del", 64'(o_del), 64'(1'b0));
    chk("R9", "reset i_ready", 64'(i_ready), 64'(1'b1));

    // table walk: drive beat i, compare at next falling edge
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      if (i == 0) drive(v[47:45], v[44:37], v[36:34], v[33:26], v[25]);
      @(negedge clk);
      if (v[24]) chk_beat($sformatf("vec%0d", i), v[23:21], v[20:13], v[12:10], v[9:2], v[1]);
      else chk("R6", $sformatf("vec%0d withheld", i), 64'(o_valid), 64'(1'b0));
      chk("R8", $sformatf("vec%0d del pulse", i), 64'(o_del), 64'(v[0]));
      if (i < NV - 1) begin
        logic [47:0] nx;
        nx = VEC[i+1];
        drive(nx[47:45], nx[44:37], nx[36:34], nx[33:26], nx[25]);
      end
    end

    // R9 stall: output D28/D29 held, carry holds D30
    o_ready = 1'b0;
    drive(KD, 8'd40, KD, 8'd41, 1'b0);
    #1;
    chk("R9", "stall i_ready", 64'(i_ready), 64'(1'b0));
    @(negedge clk);
    chk_beat("R9 stalled", KD, 8'd28, KD, 8'd29, 1'b0);
    o_ready = 1'b1;
    @(negedge clk);
    chk_beat("R9 released", KD, 8'd30, KD, 8'd40, 1'b0);
    i_valid = 1'b0;
    @(negedge clk);
    chk("R6", "drained valid", 64'(o_valid), 64'(1'b0));
    chk("R8", "bubble del", 64'(o_del), 64'(1'b0));

    // R10 mid-run reset clears carry (D41) and previous-upper state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "in reset o_valid", 64'(o_valid), 64'(1'b0));
    rst_n = 1'b1;
    drive(KI, 8'd52, KD, 8'd53, 1'b1);  // R2 prev upper counts as data after reset
    @(negedge clk);
    chk("R6", "after reset withheld", 64'(o_valid), 64'(1'b0));
    chk("R8", "after reset del", 64'(o_del), 64'(1'b1));
    drive(KD, 8'd54, KD, 8'd55, 1'b0);
    @(negedge clk);
    chk_beat("R10 fresh carry", KD, 8'd53, KD, 8'd54, 1'b1);
    i_valid = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule